// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous burst memory. Either of two active-low address strobes captures an external address. The bits above bit 1 are then held fixed. The low two bits step through a four-beat pattern each time the active-low advance input is sampled low. A static order-select input picks the pattern:

- Linear: the low two bits count up modulo 4 from the loaded value.
- Interleaved: the low two bits are the loaded value XOR the beat count.

Bursts are optional. The memory controller can load a fresh address on every cycle. Both outputs come from registers: the full current address and the beat index within the burst. Each takes its new value in the cycle after the clock edge that sampled the controls.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_out` becomes 0 and `beat` becomes 0.
- R2: If `strobe_a_n` or `strobe_b_n` is low at an edge, then after that edge `addr_out` equals the `addr_in` sampled at that edge and `beat` is 0.
- R3: A load takes priority over an advance. With a strobe low and `adv_n` low at the same edge, the result is the load described in R2.
- R4: With `order_il` = 0 (linear), after each advance the low two bits equal (start + beat) mod 4. Start is the value of `addr_in[1:0]` at the load.
- R5: With `order_il` = 1 (interleaved), after each advance the low two bits equal start XOR beat.
- R6: An advance with both strobes high and `adv_n` low raises `beat` by one modulo 4. The fourth advance after a load returns the low bits to the start value and `beat` to 0.
- R7: When both strobes and `adv_n` are high at an edge, `addr_out` and `beat` keep their values.
- R8: `addr_out[ADDR_W-1:2]` stays equal to the loaded upper bits at every edge with no strobe low.
- R9: Loads on consecutive cycles each take effect, with no burst needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_a_n | input | 1 | First address strobe, active low |
| strobe_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved; held static |
| addr_in | input | ADDR_W | External address captured on a load |
| addr_out | output | ADDR_W | Registered current burst address |
| beat | output | 2 | Registered beat index, 0 to 3 |

## Verification
The assertions assume that `order_il` changes only at an edge where a strobe is low. The hold and step checks compare the new output with the previous one, so a change of order mid-burst would break them. The stimulus changes `order_il` only together with a load strobe. Every other control is driven on the falling edge, so each rising edge samples settled values. The sweep covers both orders, all four start values and both strobes, and also exercises combined load and advance and a run of back-to-back loads.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef logic [1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // low address bits for a given start value and beat count
  function automatic beat_t bag_low(input beat_t start, input beat_t cnt, input order_e ord);
    if (ord == ORD_XOR) return start ^ cnt;
    return beat_t'(start + cnt);
  endfunction
endpackage

// File: rtl/bag_load_reg.sv
module bag_load_reg #(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [ADDR_W-1:0]   addr_in,
  output logic [ADDR_W-1:2]   upper_d,
  output bag_pkg::beat_t      start_d
);
  logic [ADDR_W-1:2] upper_q;
  bag_pkg::beat_t    start_q;

  always_comb begin
    upper_d = load ? addr_in[ADDR_W-1:2] : upper_q;
    start_d = load ? addr_in[1:0]        : start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
    end else begin
      upper_q <= upper_d;
      start_q <= start_d;
    end
  end

  // the captured start must not move without a load
  assert_start_held_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> start_q == $past(start_q));
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  output bag_pkg::beat_t beat_d,
  output bag_pkg::beat_t beat_q
);
  always_comb begin
    if (load)      beat_d = '0;
    else if (step) beat_d = bag_pkg::beat_t'(beat_q + 2'd1);
    else           beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end

  assert_beat_clear_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> beat_q == 2'd0);
  assert_beat_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && step && beat_q == 2'd3) |=> beat_q == 2'd0);
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map (
  input  bag_pkg::order_e ord,
  input  bag_pkg::beat_t  start,
  input  bag_pkg::beat_t  cnt,
  output bag_pkg::beat_t  low
);
  always_comb low = bag_pkg::bag_low(start, cnt, ord);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic              adv_n,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);
  localparam int UPPER_W = ADDR_W - 2;

  logic               load, step;
  logic [UPPER_W-1:0] upper_d;
  bag_pkg::beat_t     start_d, beat_d, beat_q, low_d;
  bag_pkg::order_e    ord;

  always_comb begin
    load = !strobe_a_n || !strobe_b_n;
    step = !adv_n && !load;
    ord  = bag_pkg::order_e'(order_il);
  end

  bag_load_reg #(.ADDR_W(ADDR_W)) u_load (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in),
    .upper_d(upper_d), .start_d(start_d)
  );

  bag_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .beat_d(beat_d), .beat_q(beat_q)
  );

  bag_order_map u_map (
    .ord(ord), .start(start_d), .cnt(beat_d), .low(low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_out <= '0;
    else     addr_out <= {upper_d, low_d};
  end

  assign beat = beat_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && beat == 2'd0));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_out == $past(addr_in));
  assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !adv_n) |=> beat == 2'd0);
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !order_il) |=> addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1));
  assert_xor_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && order_il) |=> (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat)));
  assert_beat_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> beat == 2'($past(beat) + 2'd1));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> ($stable(addr_out) && $stable(beat)));
  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sa_n = 1'b1, sb_n = 1'b1, adv_n = 1'b1, ord = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [AW-1:0] a_out;
  logic [1:0]    bt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .strobe_a_n(sa_n), .strobe_b_n(sb_n),
    .adv_n(adv_n), .order_il(ord), .addr_in(a_in), .addr_out(a_out), .beat(bt)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input logic a_n, input logic b_n, input logic v_n, input logic [AW-1:0] a);
    sa_n = a_n; sb_n = b_n; adv_n = v_n; a_in = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_low(input int s, input int b, input logic o);
    return o ? (s ^ b) : ((s + b) % 4);
  endfunction

  initial begin
    logic [AW-1:0] a;
    int up;
    repeat (3) @(negedge clk);
    chk("R1 addr", a_out, 0);
    chk("R1 beat", bt, 0);
    rst = 1'b0;
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int sel = 0; sel < 2; sel++) begin
          up = (o * 37 + s * 11 + sel * 5 + 3) % 64;
          a = AW'(up * 4 + s);
          ord = o[0];
          if (sel == 0) cyc(1'b0, 1'b1, 1'b1, a);
          else          cyc(1'b1, 1'b0, 1'b1, a);
          chk("R2 addr", a_out, a);
          chk("R2 beat", bt, 0);
          for (int k = 1; k <= 5; k++) begin
            cyc(1'b1, 1'b1, 1'b0, ~a);
            chk(o ? "R5 low" : "R4 low", a_out[1:0], exp_low(s, k % 4, o[0]));
            chk("R6 beat", bt, k % 4);
            chk("R8 upper", a_out[AW-1:2], up);
            if (k == 4) chk("R6 wrap", a_out[1:0], s);
          end
          cyc(1'b1, 1'b1, 1'b1, ~a);
          chk("R7 hold addr", a_out, up * 4 + exp_low(s, 1, o[0]));
          chk("R7 hold beat", bt, 1);
          // load with advance requested in the same cycle
          a = AW'((up + 1) % 64 * 4 + (3 - s));
          cyc(1'b0, 1'b0, 1'b0, a);
          chk("R3 addr", a_out, a);
          chk("R3 beat", bt, 0);
        end
      end
    end
    for (int i = 0; i < 16; i++) begin
      a = AW'(i * 13 + 7);
      cyc(i[0], !i[0], i[1], a);
      chk("R9 addr", a_out, a);
      chk("R9 beat", bt, 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule